// File: doc/BRIEF.md
# SDRAM Mode Register Command Handler

This block sits on the device side of a double-data-rate SDRAM command bus. It samples chip select, the row, column and write strobes, the bank address and the row address on every rising clock edge. It picks out the command that loads the mode register and checks whether that command may be taken. Once a command is accepted, a two-cycle write window begins. At the end of that window the captured address bits become the live configuration.

The stored configuration is decoded for the rest of the device:
- read latency in half-cycle units, so the 2.5-cycle setting fits integer logic;
- burst length in beats;
- burst ordering;
- test mode.

A one-cycle pulse requests a delay-locked-loop reset. Separate flags mark reserved latency or length codes.

A command that arrives inside the write window is dropped and reported. A load attempt made while the banks are busy, or while the clock enable was low in the previous cycle, is rejected. The rejection sets an error flag that stays set until reset. The all-banks-idle condition comes from outside the block.

Top module: `sdr_modereg_ctl`

## Requirements
- R1: A load command is seen when chip select, row strobe, column strobe and write strobe are all low with bank bit 0 low. It is accepted when the banks are idle, clock enable was high in the previous cycle and no write is in progress.
- R2: The same strobes with bank bit 0 high and bank bit 1 low address the extended register. Such a command leaves every output of this block unchanged.
- R3: After acceptance, busy is high for exactly two cycles. The new fields appear on the outputs in the cycle after the second busy cycle, and the valid flag is set at that point.
- R4: A command is chip select low with the three strobes not all high. A command seen while busy is high produces a one-cycle busy_violation pulse in the next cycle and has no effect on the stored fields.
- R5: Stored fields keep their value until the next accepted load completes.
- R6: Address bits 2:0 select the burst length: 001 gives 2, 010 gives 4 and 011 gives 8. Any other code gives burst_len 0 and raises bl_reserved.
- R7: Address bit 3 selects the burst order: 0 gives burst_interleave low (sequential) and 1 gives it high.
- R8: Address bits 6:4 select the latency in half cycles: 010 gives 4, 110 gives 5 and 011 gives 6. Any other code gives 0 and raises cl_reserved.
- R9: Address bit 7 set at load drives test_mode high, and clear drives it low.
- R10: When a write completes with address bit 8 set, dll_reset_pulse is high for exactly one cycle, namely the cycle the new fields appear.
- R11: A load command rejected because the banks are not idle or clock enable was low in the previous cycle sets precond_err, which stays high until reset. The stored fields are left unchanged and busy stays low.
- R12: After reset the outputs show latency 4 half cycles, burst length 2, sequential order and normal mode. cfg_valid, busy, busy_violation, precond_err and dll_reset_pulse are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write strobe, active low |
| cmd_ba | input | 2 | Bank address |
| cmd_addr | input | 13 | Row address carrying the mode fields |
| cmd_cke | input | 1 | Clock enable |
| banks_idle | input | 1 | All banks idle, from bank logic |
| cas_lat_half | output | 3 | Read latency in half cycles, 0 if reserved |
| burst_len | output | 4 | Burst length in beats, 0 if reserved |
| burst_interleave | output | 1 | 1 for interleaved burst order |
| test_mode | output | 1 | Test mode selected |
| dll_reset_pulse | output | 1 | One-cycle delay-locked-loop reset request |
| cl_reserved | output | 1 | Stored latency code is reserved |
| bl_reserved | output | 1 | Stored length code is reserved |
| cfg_valid | output | 1 | At least one load has completed |
| busy | output | 1 | Write window in progress |
| busy_violation | output | 1 | Command arrived during the write window |
| precond_err | output | 1 | Sticky rejection flag |

## Verification
A vector table loads every legal latency and length code, each reserved-code class, both burst orders, test mode and the delay-locked-loop request, which separates a wrong field decode from a wrong bit slice. Directed patterns check the timing and acceptance rules. One pattern places the extended-register command beside the real one, which separates a full bank-address decode from a partial one. Another issues a second load inside the write window, which shows whether busy blocks it and whether the first value wins. Loads made with busy banks, and loads made right after a low clock enable, tell the two rejection causes apart, and both must leave the fields untouched.

// File: rtl/sdr_mr_pkg.sv
// Package: shared command kinds, stored field layout and decode helpers
// for the mode register handler. Assumes the DDR field positions on the row address.
package sdr_mr_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_EXT   = 2'd2,
        CMD_OTHER = 2'd3
    } cmd_kind_t;

    typedef struct packed {
        logic       dll;
        logic       tm;
        logic [2:0] cl_code;
        logic       bt;
        logic [2:0] bl_code;
    } mr_fields_t;

    localparam logic [2:0] BL_RESET_CODE = 3'b001;
    localparam logic [2:0] CL_RESET_CODE = 3'b010;

    // Burst length in beats from the code, 0 when the code is reserved.
    function automatic logic [3:0] bl_beats(input logic [2:0] code);
        case (code)
            3'b001:  bl_beats = 4'd2;
            3'b010:  bl_beats = 4'd4;
            3'b011:  bl_beats = 4'd8;
            default: bl_beats = 4'd0;
        endcase
    endfunction

    // Latency in half cycles from the code, 0 when the code is reserved.
    function automatic logic [2:0] cl_halves(input logic [2:0] code);
        case (code)
            3'b010:  cl_halves = 3'd4;
            3'b110:  cl_halves = 3'd5;
            3'b011:  cl_halves = 3'd6;
            default: cl_halves = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdr_mr_cmd_decode.sv
// Command classifier: turns the raw strobes of one bus cycle into a command kind.
// Assumes the strobes are already aligned to the rising clock edge.
module sdr_mr_cmd_decode
    import sdr_mr_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    output cmd_kind_t       kind
);

    // Classify the cycle: no-op or deselect, main load, extended load, other.
    always_comb begin
        if (cs_n || (ras_n && cas_n && we_n)) begin
            kind = CMD_NONE;
        end else if (!ras_n && !cas_n && !we_n && !ba[0]) begin
            kind = CMD_LOAD;
        end else if (!ras_n && !cas_n && !we_n && ba[0] && !ba[1]) begin
            kind = CMD_EXT;
        end else begin
            kind = CMD_OTHER;
        end
    end

endmodule

// File: rtl/sdr_mr_write_seq.sv
// Write sequencer: checks the acceptance rules, runs the write window
// counter and raises the violation and precondition flags.
// Assumes banks_idle is valid in the same cycle as the command.
module sdr_mr_write_seq
    import sdr_mr_pkg::*;
#(
    parameter int WRITE_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_kind_t kind,
    input  logic      cke,
    input  logic      banks_idle,
    output logic      accept,
    output logic      commit,
    output logic      busy,
    output logic      busy_violation,
    output logic      precond_err
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] win_cnt;
    logic             cke_prev;
    logic             load_seen;

    // Acceptance and completion strobes derived from the current cycle.
    always_comb begin
        load_seen = (kind == CMD_LOAD);
        busy      = (win_cnt != '0);
        accept    = load_seen && !busy && banks_idle && cke_prev;
        commit    = (win_cnt == CNT_LAST);
    end

    // Remember clock enable from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev <= 1'b0;
        else        cke_prev <= cke;
    end

    // Count down the write window after an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)      win_cnt <= '0;
        else if (accept) win_cnt <= CNT_LOAD;
        else if (busy)   win_cnt <= win_cnt - CNT_LAST;
    end

    // Flag any command that lands inside the write window.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_violation <= 1'b0;
        else        busy_violation <= busy && (kind != CMD_NONE);
    end

    // Sticky flag for loads refused on bank or clock-enable grounds.
    always_ff @(posedge clk) begin
        if (!rst_n) precond_err <= 1'b0;
        else if (load_seen && !busy && (!banks_idle || !cke_prev))
                    precond_err <= 1'b1;
    end

endmodule

// File: rtl/sdr_mr_field_store.sv
// Field store: captures the address at acceptance, installs it at commit,
// emits the DLL reset pulse and decodes the stored codes.
// Assumes accept and commit never coincide.
module sdr_mr_field_store
    import sdr_mr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        cas_lat_half,
    output logic [3:0]        burst_len,
    output logic              burst_interleave,
    output logic              test_mode,
    output logic              dll_reset_pulse,
    output logic              cl_reserved,
    output logic              bl_reserved,
    output logic              cfg_valid
);

    localparam mr_fields_t RESET_FIELDS = '{
        dll: 1'b0, tm: 1'b0, cl_code: CL_RESET_CODE, bt: 1'b0, bl_code: BL_RESET_CODE
    };

    mr_fields_t pend_q;
    mr_fields_t live_q;

    // Capture the mode bits on the accepted command cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= RESET_FIELDS;
        else if (accept) pend_q <= mr_fields_t'(addr[8:0]);
    end

    // Install the captured bits and set the valid flag at write completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q    <= RESET_FIELDS;
            cfg_valid <= 1'b0;
        end else if (commit) begin
            live_q    <= pend_q;
            cfg_valid <= 1'b1;
        end
    end

    // One-cycle DLL reset request when a write carrying it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) dll_reset_pulse <= 1'b0;
        else        dll_reset_pulse <= commit && pend_q.dll;
    end

    // Decode the live codes for the rest of the device.
    always_comb begin
        cas_lat_half     = cl_halves(live_q.cl_code);
        burst_len        = bl_beats(live_q.bl_code);
        cl_reserved      = (cas_lat_half == 3'd0);
        bl_reserved      = (burst_len == 4'd0);
        burst_interleave = live_q.bt;
        test_mode        = live_q.tm;
    end

endmodule

// File: rtl/sdr_modereg_ctl.sv
// Top: mode register command handler. Watches the command bus, accepts loads
// under the idle and clock-enable rules, and presents the decoded configuration.
// Assumes bank idle state is tracked elsewhere.
module sdr_modereg_ctl
    import sdr_mr_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int BA_W         = 2,
    parameter int WRITE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_cs_n,
    input  logic              cmd_ras_n,
    input  logic              cmd_cas_n,
    input  logic              cmd_we_n,
    input  logic [BA_W-1:0]   cmd_ba,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_cke,
    input  logic              banks_idle,
    output logic [2:0]        cas_lat_half,
    output logic [3:0]        burst_len,
    output logic              burst_interleave,
    output logic              test_mode,
    output logic              dll_reset_pulse,
    output logic              cl_reserved,
    output logic              bl_reserved,
    output logic              cfg_valid,
    output logic              busy,
    output logic              busy_violation,
    output logic              precond_err
);

    cmd_kind_t kind;
    logic      accept;
    logic      commit;

    sdr_mr_cmd_decode #(.BA_W(BA_W)) u_dec (
        .cs_n  (cmd_cs_n),
        .ras_n (cmd_ras_n),
        .cas_n (cmd_cas_n),
        .we_n  (cmd_we_n),
        .ba    (cmd_ba),
        .kind  (kind)
    );

    sdr_mr_write_seq #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .kind           (kind),
        .cke            (cmd_cke),
        .banks_idle     (banks_idle),
        .accept         (accept),
        .commit         (commit),
        .busy           (busy),
        .busy_violation (busy_violation),
        .precond_err    (precond_err)
    );

    sdr_mr_field_store #(.ADDR_W(ADDR_W)) u_store (
        .clk              (clk),
        .rst_n            (rst_n),
        .accept           (accept),
        .commit           (commit),
        .addr             (cmd_addr),
        .cas_lat_half     (cas_lat_half),
        .burst_len        (burst_len),
        .burst_interleave (burst_interleave),
        .test_mode        (test_mode),
        .dll_reset_pulse  (dll_reset_pulse),
        .cl_reserved      (cl_reserved),
        .bl_reserved      (bl_reserved),
        .cfg_valid        (cfg_valid)
    );

endmodule

// File: rtl/sdr_mr_chk.sv
// Checker: temporal properties of the mode register handler, bound to the top.
// Assumes the default two-cycle write window.
module sdr_mr_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic [BA_W-1:0]   cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_cke,
    input logic              banks_idle,
    input logic [2:0]        cas_lat_half,
    input logic [3:0]        burst_len,
    input logic              burst_interleave,
    input logic              test_mode,
    input logic              dll_reset_pulse,
    input logic              cl_reserved,
    input logic              bl_reserved,
    input logic              cfg_valid,
    input logic              busy,
    input logic              busy_violation,
    input logic              precond_err
);

    logic cke_q;
    logic load_cmd;
    logic any_cmd;

    // Independent copy of last-cycle clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b0;
        else        cke_q <= cmd_cke;
    end

    // Command recognition from the bus pins.
    always_comb begin
        load_cmd = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && !cmd_we_n && !cmd_ba[0];
        any_cmd  = !cmd_cs_n && !(cmd_ras_n && cmd_cas_n && cmd_we_n);
    end

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd && banks_idle && cke_q && !busy |=> busy);

    p_busy_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    p_violation_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && any_cmd |=> busy_violation);

    p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(cas_lat_half) && $stable(burst_len)
                  && $stable(burst_interleave) && $stable(test_mode));

    p_cl_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cl_reserved |-> (cas_lat_half >= 3'd4 && cas_lat_half <= 3'd6));

    p_dll_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset_pulse |=> !dll_reset_pulse);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        precond_err |=> precond_err);

    p_refused_no_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd && !busy && !banks_idle |=> !busy);

endmodule

bind sdr_modereg_ctl sdr_mr_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (.*);

// File: tb/sdr_modereg_ctl_tb.sv
// Bench: vector table of load codes followed by directed timing and rule tests.
module sdr_modereg_ctl_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [8:0] addr;
        logic [2:0] cl;
        logic [3:0] bl;
        logic       bt;
        logic       tm;
        logic       dll;
        logic       clr;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{addr: 9'b0_0_010_0_010, cl: 3'd4, bl: 4'd4, bt: 1'b0, tm: 1'b0, dll: 1'b0, clr: 1'b0},
        '{addr: 9'b0_0_011_1_011, cl: 3'd6, bl: 4'd8, bt: 1'b1, tm: 1'b0, dll: 1'b0, clr: 1'b0},
        '{addr: 9'b0_0_110_0_001, cl: 3'd5, bl: 4'd2, bt: 1'b0, tm: 1'b0, dll: 1'b0, clr: 1'b0},
        '{addr: 9'b0_0_000_0_010, cl: 3'd0, bl: 4'd4, bt: 1'b0, tm: 1'b0, dll: 1'b0, clr: 1'b1},
        '{addr: 9'b0_0_011_1_000, cl: 3'd6, bl: 4'd0, bt: 1'b1, tm: 1'b0, dll: 1'b0, clr: 1'b0},
        '{addr: 9'b0_0_111_0_111, cl: 3'd0, bl: 4'd0, bt: 1'b0, tm: 1'b0, dll: 1'b0, clr: 1'b1},
        '{addr: 9'b0_1_010_0_001, cl: 3'd4, bl: 4'd2, bt: 1'b0, tm: 1'b1, dll: 1'b0, clr: 1'b0},
        '{addr: 9'b1_0_011_0_011, cl: 3'd6, bl: 4'd8, bt: 1'b0, tm: 1'b0, dll: 1'b1, clr: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [1:0]  cmd_ba;
    logic [12:0] cmd_addr;
    logic        cmd_cke;
    logic        banks_idle;
    logic [2:0]  cas_lat_half;
    logic [3:0]  burst_len;
    logic        burst_interleave, test_mode, dll_reset_pulse;
    logic        cl_reserved, bl_reserved, cfg_valid, busy, busy_violation, precond_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_modereg_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
        .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .cmd_cke(cmd_cke), .banks_idle(banks_idle),
        .cas_lat_half(cas_lat_half), .burst_len(burst_len), .burst_interleave(burst_interleave),
        .test_mode(test_mode), .dll_reset_pulse(dll_reset_pulse), .cl_reserved(cl_reserved),
        .bl_reserved(bl_reserved), .cfg_valid(cfg_valid), .busy(busy),
        .busy_violation(busy_violation), .precond_err(precond_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_nop();
        cmd_cs_n = 1'b0; cmd_ras_n = 1'b1; cmd_cas_n = 1'b1; cmd_we_n = 1'b1;
        cmd_ba = 2'b00;  cmd_addr = '0;
    endtask

    // Drive a load-style command for one cycle, then return to no-op.
    task automatic issue_load(input logic [1:0] ba, input logic [8:0] a);
        @(negedge clk);
        cmd_cs_n = 1'b0; cmd_ras_n = 1'b0; cmd_cas_n = 1'b0; cmd_we_n = 1'b0;
        cmd_ba = ba; cmd_addr = {4'b0, a};
        @(negedge clk);
        drive_nop();
    endtask

    task automatic check_fields(input string req, input logic [2:0] cl, input logic [3:0] bl,
                                input logic bt, input logic tm);
        check(req, 8'(cas_lat_half), 8'(cl));
        check(req, 8'(burst_len), 8'(bl));
        check(req, 8'(burst_interleave), 8'(bt));
        check(req, 8'(test_mode), 8'(tm));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_cke = 1'b1; banks_idle = 1'b1;
        cmd_cs_n = 1'b1; cmd_ras_n = 1'b1; cmd_cas_n = 1'b1; cmd_we_n = 1'b1;
        cmd_ba = '0; cmd_addr = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check_fields("R12", 3'd4, 4'd2, 1'b0, 1'b0);
        check("R12", 8'(cfg_valid), 8'd0);
        check("R12", 8'(busy), 8'd0);
        check("R12", 8'(precond_err), 8'd0);
        check("R12", 8'(dll_reset_pulse), 8'd0);
        rst_n = 1'b1;
        drive_nop();
        @(negedge clk);

        // Vector table: R1 R6 R7 R8 R9 R10 with R3 timing
        for (int i = 0; i < 8; i++) begin
            issue_load(2'b00, VECS[i].addr);
            check("R3", 8'(busy), 8'd1);
            @(negedge clk);
            check("R3", 8'(busy), 8'd1);
            @(negedge clk);
            check("R3", 8'(busy), 8'd0);
            check("R1", 8'(cfg_valid), 8'd1);
            check_fields("R6_R7_R8_R9", VECS[i].cl, VECS[i].bl, VECS[i].bt, VECS[i].tm);
            check("R8", 8'(cl_reserved), 8'(VECS[i].clr));
            check("R6", 8'(bl_reserved), 8'(VECS[i].bl == 4'd0));
            check("R10", 8'(dll_reset_pulse), 8'(VECS[i].dll));
            @(negedge clk);
            check("R10", 8'(dll_reset_pulse), 8'd0);
        end

        // R3: fields not yet visible one cycle before completion
        issue_load(2'b00, 9'b0_0_010_0_010);
        @(negedge clk);
        check("R3", 8'(burst_len), 8'd8);
        @(negedge clk);
        check("R3", 8'(burst_len), 8'd4);

        // R2: extended register command leaves everything alone
        issue_load(2'b01, 9'b0_0_011_1_011);
        check("R2", 8'(busy), 8'd0);
        repeat (2) @(negedge clk);
        check_fields("R2", 3'd4, 4'd4, 1'b0, 1'b0);

        // R4: second load inside the window is flagged and ignored
        issue_load(2'b00, 9'b0_0_110_0_001);
        cmd_ras_n = 1'b0; cmd_cas_n = 1'b0; cmd_we_n = 1'b0; cmd_addr = 13'b0_0_011_1_011;
        @(negedge clk);
        drive_nop();
        check("R4", 8'(busy_violation), 8'd1);
        @(negedge clk);
        check("R4", 8'(busy_violation), 8'd0);
        check_fields("R4", 3'd5, 4'd2, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        // R5: value held across idle cycles
        check_fields("R5", 3'd5, 4'd2, 1'b0, 1'b0);

        // R11: banks not idle
        check("R11", 8'(precond_err), 8'd0);
        banks_idle = 1'b0;
        issue_load(2'b00, 9'b0_0_011_1_011);
        banks_idle = 1'b1;
        check("R11", 8'(busy), 8'd0);
        check("R11", 8'(precond_err), 8'd1);
        repeat (2) @(negedge clk);
        check_fields("R11", 3'd5, 4'd2, 1'b0, 1'b0);

        // R11: clock enable low in the previous cycle
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R12", 8'(precond_err), 8'd0);
        cmd_cke = 1'b0;
        @(negedge clk);
        cmd_cke = 1'b1;
        cmd_ras_n = 1'b0; cmd_cas_n = 1'b0; cmd_we_n = 1'b0; cmd_addr = 13'b0_0_011_1_011;
        @(negedge clk);
        drive_nop();
        check("R11", 8'(busy), 8'd0);
        check("R11", 8'(precond_err), 8'd1);
        repeat (2) @(negedge clk);
        check_fields("R11", 3'd4, 4'd2, 1'b0, 1'b0);
        check("R11", 8'(cfg_valid), 8'd0);
        @(negedge clk);
        check("R11", 8'(precond_err), 8'd1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule